// File: doc/BRIEF.md
# Prescaled Alarm Timer Group

This block holds a parameterised number of general-purpose timers (two by default) behind a flat register interface. Each timer owns a 64-bit counter. The counter steps once per tick of the timer's own clock prescaler. Software chooses, per timer, whether the counter runs or holds, and whether it counts up or down. It can force the counter to a preset value through a strobe, and it sets an alarm value.

When a counter step lands exactly on the alarm value and the alarm is enabled, the timer's status bit is set. The counter can optionally be reloaded with the preset value at that moment, which makes the timer periodic. A single level interrupt output is raised while any status bit is enabled both by its timer's interrupt enable and by the group mask. Software clears a status bit by writing 1 to it in the clear register.

Writes and reads use one cycle each and have no handshake. A write takes effect at the next clock edge. The read data is a combinational function of the read address and the block's registers.

Top module: `tmr_group`

## Requirements
- R1: Address map: bit 4 set selects the group registers (0 status, 1 write-1-to-clear, 2 interrupt mask). Bit 4 clear selects timer bit 3, with slot bits 2:0 as follows: 0 config, 1 preset, 2 load strobe, 3 alarm, 4 count (read only). After reset every register, counter and status bit reads 0. Each timer keeps its own config, counter and status bit.
- R2: A load-strobe write copies the preset value into the counter. An arbitrary value such as 0x30405000 reads back unchanged from a paused counter.
- R3: The config field bits 31:16 sets the divide ratio. A value of 0 divides by 65536, a value of 1 divides by 2, and any other value N divides by N. A config write or a pause restarts the prescaler, so the first step comes one full ratio of cycles after the config write.
- R4: Config bit 1 selects the direction: 1 counts up by one per tick, 0 counts down by one per tick.
- R5: Config bit 0 runs the timer. While it is 0 the counter holds its value, and when it returns to 1 counting resumes from the held value.
- R6: With config bit 2 set, a step whose result equals the alarm value sets that timer's status bit, and the counter keeps running past it. With bit 2 clear, no status bit is ever set.
- R7: With config bit 3 set, the alarm step loads the preset value instead of the stepped value, so alarms repeat every (alarm minus preset) ticks when counting up.
- R8: irq is high exactly when some status bit is set while both that timer's config bit 4 and its group mask bit are set.
- R9: Writing 1 to a bit of the clear register clears that status bit. If an alarm step falls in the same cycle, the bit stays set.
- R10: A load strobe in the same cycle as a prescaler tick wins: the counter takes the preset value, and that step makes no alarm check.
- R11: The alarm match is an equality test on the stepped value. An alarm the counter has already passed fires only after a wrap, and a down-count from 0 wraps to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land on the same edge: a status clear with a new alarm step, and a load strobe with a prescaler tick. The bench provokes each pair by counting edges from the config write that restarts a divide-by-2 prescaler, then issuing the clear or the strobe on the tick edge. For the first pair it expects the status bit to survive the coinciding clear and to fall on a following one. For the second it expects the counter to hold exactly the preset value, one step before counting resumes. A behavioural model of the whole group is also compared with the interrupt and the read data on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DIV_W  = 16;
    localparam int SLOT_W = 3;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             irq_en;
        logic             reload;
        logic             alarm_en;
        logic             up;
        logic             run;
    } tmr_cfg_t;

    typedef enum logic [SLOT_W-1:0] {
        RG_CFG    = 3'd0,
        RG_PRESET = 3'd1,
        RG_STROBE = 3'd2,
        RG_ALARM  = 3'd3,
        RG_COUNT  = 3'd4
    } tmr_slot_e;

    typedef enum logic [SLOT_W-1:0] {
        GR_STATUS = 3'd0,
        GR_CLEAR  = 3'd1,
        GR_MASK   = 3'd2
    } grp_slot_e;

    // Terminal value of the prescaler count for a divide field.
    function automatic logic [DIV_W-1:0] ratio_last(input logic [DIV_W-1:0] f);
        if (f == '0)
            return '1;
        else if (f == DIV_W'(1))
            return DIV_W'(1);
        else
            return f - DIV_W'(1);
    endfunction

    function automatic logic [31:0] cfg_pack(input tmr_cfg_t c);
        return {c.div, 11'd0, c.irq_en, c.reload, c.alarm_en, c.up, c.run};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [PW-1:0] last,
    output logic          tick
);
    logic [PW-1:0] pcnt_q;

    assign tick = run && (pcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + PW'(1);
    end

    // R3: the smallest ratio is 2, so ticks never come back to back
    a_r3_no_double_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5: a fresh start never ticks on its first running cycle
    a_r5_start_no_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !tick);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_stb,
    input  logic             run,
    input  logic             up,
    input  logic             alarm_en,
    input  logic             reload,
    input  logic [CNT_W-1:0] preset,
    input  logic [CNT_W-1:0] alarm_val,
    output logic [CNT_W-1:0] cnt,
    output logic             alarm_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stepped;

    assign stepped   = up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
    assign alarm_evt = tick && !load_stb && alarm_en && (stepped == alarm_val);
    assign cnt       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_stb)
            cnt_q <= preset;
        else if (tick)
            cnt_q <= (alarm_evt && reload) ? preset : stepped;
    end

    // R5: a paused counter without a strobe holds
    a_r5_paused_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_stb) |=> cnt_q == $past(cnt_q));

    // R10: the strobe beats any tick
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> cnt_q == $past(preset));

    // R4: plain up and down steps
    a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
        (tick && up && !load_stb && !alarm_evt) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !up && !load_stb && !alarm_evt) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 64,
    parameter int ADDR_W     = SLOT_W + $clog2(NUM_TIMERS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - SLOT_W - 1;

    tmr_cfg_t               cfg_q    [NUM_TIMERS];
    logic [CNT_W-1:0]       preset_q [NUM_TIMERS];
    logic [CNT_W-1:0]       alarm_q  [NUM_TIMERS];
    logic [CNT_W-1:0]       cnt_w    [NUM_TIMERS];
    logic [NUM_TIMERS-1:0]  status_q, mask_q;
    logic [NUM_TIMERS-1:0]  evt_vec, tick_vec, tsel, cfg_wr, ld_stb, clr_vec, ien_vec;

    logic             w_grp, r_grp;
    logic [IDX_W-1:0] w_idx, r_idx;
    tmr_slot_e        w_tslot, r_tslot;
    grp_slot_e        w_gslot, r_gslot;

    assign w_grp   = wr_addr[ADDR_W-1];
    assign w_idx   = wr_addr[ADDR_W-2:SLOT_W];
    assign w_tslot = tmr_slot_e'(wr_addr[SLOT_W-1:0]);
    assign w_gslot = grp_slot_e'(wr_addr[SLOT_W-1:0]);
    assign r_grp   = rd_addr[ADDR_W-1];
    assign r_idx   = rd_addr[ADDR_W-2:SLOT_W];
    assign r_tslot = tmr_slot_e'(rd_addr[SLOT_W-1:0]);
    assign r_gslot = grp_slot_e'(rd_addr[SLOT_W-1:0]);

    assign clr_vec = (wr_en && w_grp && w_gslot == GR_CLEAR) ? wr_data[NUM_TIMERS-1:0] : '0;

    generate
        for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
            assign tsel[i]    = wr_en && !w_grp && (w_idx == IDX_W'(i));
            assign cfg_wr[i]  = tsel[i] && (w_tslot == RG_CFG);
            assign ld_stb[i]  = tsel[i] && (w_tslot == RG_STROBE);
            assign ien_vec[i] = cfg_q[i].irq_en;

            tmr_prescaler #(.PW(DIV_W)) u_pre (
                .clk     (clk),
                .rst     (rst),
                .run     (cfg_q[i].run),
                .restart (cfg_wr[i]),
                .last    (ratio_last(cfg_q[i].div)),
                .tick    (tick_vec[i])
            );

            tmr_channel #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick_vec[i]),
                .load_stb  (ld_stb[i]),
                .run       (cfg_q[i].run),
                .up        (cfg_q[i].up),
                .alarm_en  (cfg_q[i].alarm_en),
                .reload    (cfg_q[i].reload),
                .preset    (preset_q[i]),
                .alarm_val (alarm_q[i]),
                .cnt       (cnt_w[i]),
                .alarm_evt (evt_vec[i])
            );

            // R6: a status bit can only rise from an enabled alarm
            a_r6_rise_needs_alarm: assert property (@(posedge clk) disable iff (rst)
                $rose(status_q[i]) |-> $past(cfg_q[i].alarm_en));

            // R9: a clear without a coinciding alarm step takes effect
            a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[i] && !evt_vec[i]) |=> !status_q[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TIMERS; i++) begin
                cfg_q[i]    <= '0;
                preset_q[i] <= '0;
                alarm_q[i]  <= '0;
            end
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= evt_vec | (status_q & ~clr_vec);
            if (wr_en && w_grp && w_gslot == GR_MASK)
                mask_q <= wr_data[NUM_TIMERS-1:0];
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (tsel[i]) begin
                    case (w_tslot)
                        RG_CFG: cfg_q[i] <= '{div:      wr_data[31:16],
                                               irq_en:   wr_data[4],
                                               reload:   wr_data[3],
                                               alarm_en: wr_data[2],
                                               up:       wr_data[1],
                                               run:      wr_data[0]};
                        RG_PRESET: preset_q[i] <= wr_data;
                        RG_ALARM:  alarm_q[i]  <= wr_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (r_grp) begin
            case (r_gslot)
                GR_STATUS: rd_data[NUM_TIMERS-1:0] = status_q;
                GR_MASK:   rd_data[NUM_TIMERS-1:0] = mask_q;
                default: ;
            endcase
        end else begin
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (r_idx == IDX_W'(i)) begin
                    case (r_tslot)
                        RG_CFG:    rd_data = CNT_W'(cfg_pack(cfg_q[i]));
                        RG_PRESET: rd_data = preset_q[i];
                        RG_ALARM:  rd_data = alarm_q[i];
                        RG_COUNT:  rd_data = cnt_w[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    assign irq = |(status_q & ien_vec & mask_q);

endmodule

// File: tb/tb_tmr_group.sv
module tb_tmr_group;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_group dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_cnt [2];
    logic [63:0] m_pre_v [2];
    logic [63:0] m_alarm [2];
    int          m_psc [2];
    logic [15:0] m_div [2];
    logic        m_run [2], m_up [2], m_aen [2], m_rel [2], m_ien [2];
    logic [1:0]  m_stat, m_mask;

    function automatic logic [63:0] m_read(input logic [4:0] a);
        int t;
        t = a[3];
        if (a[4]) begin
            if (a[2:0] == 3'd0) return {62'd0, m_stat};
            if (a[2:0] == 3'd2) return {62'd0, m_mask};
            return 64'd0;
        end
        case (a[2:0])
            3'd0: return {32'd0, m_div[t], 11'd0, m_ien[t], m_rel[t], m_aen[t], m_up[t], m_run[t]};
            3'd1: return m_pre_v[t];
            3'd3: return m_alarm[t];
            3'd4: return m_cnt[t];
            default: return 64'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_pre_v[i] = 0; m_alarm[i] = 0; m_psc[i] = 0; m_div[i] = 0;
                m_run[i] = 0; m_up[i] = 0; m_aen[i] = 0; m_rel[i] = 0; m_ien[i] = 0;
            end
            m_stat = 0; m_mask = 0;
        end else begin
            logic [1:0] ev;
            logic [1:0] clr;
            ev = 0;
            clr = (wr_en && wr_addr[4] && wr_addr[2:0] == 3'd1) ? wr_data[1:0] : 2'd0;
            for (int i = 0; i < 2; i++) begin
                int ratio;
                logic tk, mine;
                logic [63:0] nx;
                ratio = (m_div[i] == 0) ? 65536 : (m_div[i] == 1) ? 2 : int'(m_div[i]);
                tk = m_run[i] && (m_psc[i] == ratio - 1);
                mine = wr_en && !wr_addr[4] && (int'(wr_addr[3]) == i);
                if ((mine && wr_addr[2:0] == 3'd0) || !m_run[i] || tk) m_psc[i] = 0;
                else m_psc[i] = m_psc[i] + 1;
                if (mine && wr_addr[2:0] == 3'd2) begin
                    m_cnt[i] = m_pre_v[i];
                end else if (tk) begin
                    nx = m_up[i] ? m_cnt[i] + 1 : m_cnt[i] - 1;
                    ev[i] = m_aen[i] && (nx == m_alarm[i]);
                    m_cnt[i] = (ev[i] && m_rel[i]) ? m_pre_v[i] : nx;
                end
                if (mine) begin
                    case (wr_addr[2:0])
                        3'd0: begin
                            m_run[i] = wr_data[0]; m_up[i] = wr_data[1]; m_aen[i] = wr_data[2];
                            m_rel[i] = wr_data[3]; m_ien[i] = wr_data[4]; m_div[i] = wr_data[31:16];
                        end
                        3'd1: m_pre_v[i] = wr_data;
                        3'd3: m_alarm[i] = wr_data;
                        default: ;
                    endcase
                end
            end
            m_stat = ev | (m_stat & ~clr);
            if (wr_en && wr_addr[4] && wr_addr[2:0] == 3'd2) m_mask = wr_data[1:0];
        end
    end

    // per-cycle comparison, half a period away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic exp_irq;
            exp_irq = |(m_stat & {m_ien[1], m_ien[0]} & m_mask);
            checks++;
            if (irq !== exp_irq) begin
                failures++;
                $display("FAIL R8 model irq actual=%0b expected=%0b t=%0t", irq, exp_irq, $time);
            end
            checks++;
            if (rd_data !== m_read(rd_addr)) begin
                failures++;
                $display("FAIL R1 model read addr=%0d actual=%h expected=%h t=%0t",
                         rd_addr, rd_data, m_read(rd_addr), $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    localparam logic [63:0] RUN = 1, UP = 2, AEN = 4, REL = 8, IEN = 16;
    function automatic logic [63:0] dv(input int n);
        return 64'(n) << 16;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(5'd4, v);  chk("R1 count0 after reset", v, 0);
        rd(5'd16, v); chk("R1 status after reset", v, 0);
        chk("R1 irq after reset", {63'd0, irq}, 0);

        // R2 preset strobe while paused
        wr(5'd1, 64'h30405000); wr(5'd2, 0);
        rd(5'd4, v); chk("R2 readback", v, 64'h30405000);
        idle(10);
        rd(5'd4, v); chk("R5 paused hold", v, 64'h30405000);

        // R3/R4 up, divide by 4
        wr(5'd1, 0); wr(5'd2, 0);
        wr(5'd0, RUN | UP | dv(4));
        idle(40);
        rd(5'd4, v); chk("R3 R4 div4 up", v, 10);
        wr(5'd0, UP | dv(4));
        idle(20);
        rd(5'd4, v); chk("R5 pause holds", v, 10);
        wr(5'd0, RUN | UP | dv(4));
        idle(8);
        rd(5'd4, v); chk("R5 resume from held", v, 12);

        // R3 field 1 acts as divide by 2
        wr(5'd2, 0);
        wr(5'd0, RUN | UP | dv(1));
        idle(10);
        rd(5'd4, v); chk("R3 field1 as div2", v, 5);

        // R4 down count
        wr(5'd0, 0);
        wr(5'd1, 100); wr(5'd2, 0);
        wr(5'd0, RUN | dv(2));
        idle(20);
        rd(5'd4, v); chk("R4 down", v, 90);

        // R3 field 0 divides by 65536
        wr(5'd0, 0); wr(5'd1, 0); wr(5'd2, 0);
        wr(5'd0, RUN | UP);
        idle(65535);
        rd(5'd4, v); chk("R3 div65536 before", v, 0);
        idle(1);
        rd(5'd4, v); chk("R3 div65536 first tick", v, 1);
        wr(5'd0, 0);

        // R6/R8 alarm on timer 1
        wr(5'd9, 0); wr(5'd10, 0); wr(5'd11, 5); wr(5'd18, 3);
        wr(5'd8, RUN | UP | AEN | IEN | dv(2));
        idle(10);
        rd(5'd12, v); chk("R6 count at alarm", v, 5);
        rd(5'd16, v); chk("R6 R1 status bit1 only", v, 2);
        chk("R8 irq set", {63'd0, irq}, 1);
        idle(2);
        rd(5'd12, v); chk("R6 runs past alarm", v, 6);
        wr(5'd18, 1);
        chk("R8 group mask gates", {63'd0, irq}, 0);
        wr(5'd18, 3);
        chk("R8 irq restored", {63'd0, irq}, 1);
        wr(5'd17, 2);
        rd(5'd16, v); chk("R9 clear", v, 0);
        chk("R9 irq after clear", {63'd0, irq}, 0);

        // R6 alarm disabled
        wr(5'd8, 0); wr(5'd9, 0); wr(5'd10, 0);
        wr(5'd8, RUN | UP | IEN | dv(2));
        idle(20);
        rd(5'd12, v); chk("R6 disabled count", v, 10);
        rd(5'd16, v); chk("R6 disabled no status", v, 0);

        // R11 passed alarm does not fire; wrap does
        wr(5'd8, RUN | UP | AEN | IEN | dv(2));
        idle(20);
        rd(5'd12, v); chk("R11 passed count", v, 20);
        rd(5'd16, v); chk("R11 passed no status", v, 0);
        wr(5'd8, 0); wr(5'd9, 0); wr(5'd10, 0); wr(5'd11, '1);
        wr(5'd8, RUN | AEN | IEN | dv(2));
        idle(2);
        rd(5'd12, v); chk("R11 wrap value", v, '1);
        rd(5'd16, v); chk("R11 wrap status", v, 2);
        wr(5'd17, 2); wr(5'd8, 0);

        // R7 auto reload on timer 0
        wr(5'd0, 0); wr(5'd1, 10); wr(5'd2, 0); wr(5'd3, 13);
        wr(5'd0, RUN | UP | AEN | REL | IEN | dv(2));
        idle(4);
        rd(5'd4, v); chk("R7 before alarm", v, 12);
        rd(5'd16, v); chk("R7 no status yet", v, 0);
        idle(2);
        rd(5'd4, v); chk("R7 reloaded", v, 10);
        rd(5'd16, v); chk("R7 R1 status bit0 only", v, 1);

        // R9 set beats clear in the same cycle
        wr(5'd0, 0); wr(5'd1, 0); wr(5'd2, 0); wr(5'd3, 1); wr(5'd17, 3);
        wr(5'd0, RUN | UP | AEN | REL | dv(2));
        idle(1);
        wr(5'd17, 1);
        rd(5'd16, v); chk("R9 set wins over clear", v, 1);
        wr(5'd17, 1);
        rd(5'd16, v); chk("R9 later clear", v, 0);

        // R10 strobe on a tick edge
        wr(5'd0, 0); wr(5'd3, 1000); wr(5'd1, 50);
        wr(5'd0, RUN | UP | dv(2));
        idle(1);
        wr(5'd2, 0);
        rd(5'd4, v); chk("R10 load beats tick", v, 50);
        idle(1);
        rd(5'd4, v); chk("R10 hold until tick", v, 50);
        idle(1);
        rd(5'd4, v); chk("R10 next tick", v, 51);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule